// File: doc/BRIEF.md
# Triggered Waveform Capture Buffer

The block takes one sample per channel on every clock from a set of ADC channels that are all sampled at the same instant. Each sample goes into a circular history memory that never stops writing. When a trigger pulse comes in, the block goes back a programmable number of cycles into that history and copies a fixed-length window of every channel into the readout buffer that is currently collecting. Before the samples of each stored event it writes a header word that holds the trigger number and a cycle timestamp.

There are two readout buffers, and they trade roles. One of them collects events. The other one is handed to the read side, where a word-serial port drains it one word per read strobe and shows how many words are left. The collecting buffer is handed over in two cases: when it holds its maximum number of events, or when a flush is requested. A handover happens only if the read side has already released the previous buffer. Sampling never pauses. A trigger that cannot be stored is dropped and counted, and it never disturbs an event that is already stored.

With the defaults the block captures 4 channels of 14 bits. The history holds 512 samples, a window is 8 samples long and a buffer holds 8 events. The channel count, sample width, history depth, window length, event capacity and word width are all parameters.

Top module: `wcap_top`

## Requirements
- R1: An accepted trigger stores NCH×WIN samples. For channel c, the window is the WIN consecutive samples of that channel, and the first of them is the sample presented `latency` cycles before the cycle in which `trig` is high. `latency` is read in the trigger cycle and may be any value from 0 to DEPTH−WIN.
- R2: A stored event is 1+NCH×WIN words long. Word 0 is the header. Then come the samples in channel-major order: all WIN samples of channel 0 from oldest to newest, then all of channel 1, and so on. Each sample sits in bits 13:0 of its word, and the upper bits are zero.
- R3: The header holds the trigger number in bits 31:16 and the timestamp in bits 15:0. The trigger number is the count of all `trig` pulses since reset, dropped ones included, and it starts at 0. The timestamp is the number of cycles between the release of reset and the trigger cycle.
- R4: After a trigger is accepted, `cap_busy` is high for exactly WIN cycles. A trigger in any of those cycles is dropped: `trig_drop` is high in the following cycle, `drop_cnt` goes up by one, and the event being copied is stored unchanged. A trigger WIN+1 cycles after an accepted one is accepted.
- R5: When the collecting buffer holds MAX_EV events and no buffer is handed to the read side, the collecting buffer is handed over. `rd_ready` rises and `rd_count` equals the number of events × (1+NCH×WIN).
- R6: A `flush` pulse hands over the collecting buffer once it holds at least one event and the read side is free. A `flush` pulse while the collecting buffer holds no event has no effect.
- R7: When the collecting buffer is full and the read side still holds the other buffer, `ovf` is high. Triggers are then dropped and counted as in R4.
- R8: While `rd_ready` is high, `rd_data` shows the current word. Each cycle with `rd_en` high advances one word and lowers `rd_count` by one. Without `rd_en`, the word and the count hold. After the last word is read, `rd_ready` falls and the buffer is released. A full buffer waiting for the read side is then handed over, and events come out in the order they were accepted.
- R9: After reset, `rd_ready`, `rd_count`, `cap_busy`, `ovf`, `trig_drop` and `drop_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| samp_in | input | NCH×SW | One sample per channel; channel c in bits c×SW +: SW |
| trig | input | 1 | Trigger pulse, one trigger per high cycle |
| flush | input | 1 | Request to hand over the collecting buffer |
| latency | input | log2(DEPTH) | Look-back distance in cycles |
| rd_en | input | 1 | Read strobe, advances one word |
| rd_ready | output | 1 | A buffer is available to the read side |
| rd_count | output | log2(MAX_EV×(1+NCH×WIN)+1) | Words left in the handed-over buffer |
| rd_data | output | WORD_W | Current readout word |
| cap_busy | output | 1 | Window copy in progress |
| ovf | output | 1 | Collecting buffer is full and cannot be handed over |
| trig_drop | output | 1 | The trigger of the previous cycle was dropped |
| drop_cnt | output | DROP_W | Count of dropped triggers |

## Verification
The hardest state to reach is the one where both buffers are full at once: one is parked on the read side and the other has stopped collecting. In that state `ovf` is high, and the first buffer that is released must cause an immediate handover. The bench gets there by filling one buffer so that it hands over by itself. It then fills the second buffer while the read side stays idle, fires an extra trigger that must be dropped, and finally drains both buffers one after the other while checking every word. The busy boundary gets its own test: two triggers in back-to-back cycles, placed exactly WIN and WIN+1 cycles after an accepted one, so that the first is dropped and the second is stored.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

   // state of the window copy engine
   typedef enum logic {
      CP_IDLE = 1'b0,
      CP_RUN  = 1'b1
   } copy_state_e;

endpackage

// File: rtl/wcap_pipeline.sv
// Circular sample history: written at every clock, read asynchronously.
module wcap_pipeline #(
   parameter int NCH   = 4,
   parameter int SW    = 14,
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH*SW-1:0] samp_in,
   input  logic [AW-1:0]     rd_addr,
   output logic [NCH*SW-1:0] rd_data,
   output logic [AW-1:0]     wr_ptr
);

   logic [NCH*SW-1:0] hist [DEPTH];

   always_ff @(posedge clk) begin
      hist[wr_ptr] <= samp_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         wr_ptr <= '0;
      else if (wr_ptr == AW'(DEPTH - 1))
         wr_ptr <= '0;
      else
         wr_ptr <= wr_ptr + AW'(1);
   end

   assign rd_data = hist[rd_addr];

endmodule

// File: rtl/wcap_event_bank.sv
// One readout buffer: a header store plus one sample store per channel.
module wcap_event_bank #(
   parameter int NCH        = 4,
   parameter int SW         = 14,
   parameter int WIN        = 8,
   parameter int MAX_EV     = 8,
   parameter int WORD_W     = 32,
   parameter bit SIGNED_SMP = 1'b0,
   localparam int KW        = $clog2(WIN),
   localparam int CW        = $clog2(NCH),
   localparam int SLW       = $clog2(MAX_EV)
) (
   input  logic              clk,
   input  logic              hdr_we,
   input  logic [SLW-1:0]    hdr_slot,
   input  logic [WORD_W-1:0] hdr_data,
   input  logic              smp_we,
   input  logic [SLW-1:0]    smp_slot,
   input  logic [KW-1:0]     smp_idx,
   input  logic [NCH*SW-1:0] smp_data,
   input  logic              rd_hdr,
   input  logic [SLW-1:0]    rd_slot,
   input  logic [CW-1:0]     rd_ch,
   input  logic [KW-1:0]     rd_idx,
   output logic [WORD_W-1:0] rd_word
);

   logic [WORD_W-1:0] hdr_mem [MAX_EV];
   logic [SW-1:0]     ch_q    [NCH];
   logic [SW-1:0]     ch_sel;
   logic [WORD_W-1:0] smp_word;

   always_ff @(posedge clk) begin
      if (hdr_we) hdr_mem[hdr_slot] <= hdr_data;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [SW-1:0] smp_mem [MAX_EV*WIN];
      always_ff @(posedge clk) begin
         if (smp_we) smp_mem[{smp_slot, smp_idx}] <= smp_data[c*SW +: SW];
      end
      assign ch_q[c] = smp_mem[{rd_slot, rd_idx}];
   end

   assign ch_sel = ch_q[rd_ch];

   if (SIGNED_SMP) begin : g_sext
      assign smp_word = {{(WORD_W-SW){ch_sel[SW-1]}}, ch_sel};
   end else begin : g_zext
      assign smp_word = {{(WORD_W-SW){1'b0}}, ch_sel};
   end

   assign rd_word = rd_hdr ? hdr_mem[rd_slot] : smp_word;

endmodule

// File: rtl/wcap_read_seq.sv
// Walks a handed-over buffer: header, then channel-major samples, per event.
module wcap_read_seq #(
   parameter int NCH    = 4,
   parameter int WIN    = 8,
   parameter int MAX_EV = 8,
   localparam int KW    = $clog2(WIN),
   localparam int CW    = $clog2(NCH),
   localparam int SLW   = $clog2(MAX_EV),
   localparam int EW    = $clog2(MAX_EV + 1),
   localparam int EVW   = 1 + NCH * WIN,
   localparam int RCW   = $clog2(MAX_EV * EVW + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [EW-1:0]  load_evs,
   input  logic           adv,
   output logic           rd_hdr,
   output logic [SLW-1:0] rd_slot,
   output logic [CW-1:0]  rd_ch,
   output logic [KW-1:0]  rd_idx,
   output logic [RCW-1:0] remain,
   output logic           last
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_hdr  <= 1'b1;
         rd_slot <= '0;
         rd_ch   <= '0;
         rd_idx  <= '0;
         remain  <= '0;
      end else if (load) begin
         rd_hdr  <= 1'b1;
         rd_slot <= '0;
         rd_ch   <= '0;
         rd_idx  <= '0;
         remain  <= RCW'(load_evs) * RCW'(EVW);
      end else if (adv) begin
         remain <= remain - RCW'(1);
         if (rd_hdr) begin
            rd_hdr <= 1'b0;
            rd_ch  <= '0;
            rd_idx <= '0;
         end else if (rd_idx == KW'(WIN - 1)) begin
            rd_idx <= '0;
            if (rd_ch == CW'(NCH - 1)) begin
               rd_ch   <= '0;
               rd_hdr  <= 1'b1;
               rd_slot <= rd_slot + SLW'(1);
            end else begin
               rd_ch <= rd_ch + CW'(1);
            end
         end else begin
            rd_idx <= rd_idx + KW'(1);
         end
      end
   end

   assign last = (remain == RCW'(1));

endmodule

// File: rtl/wcap_top.sv
module wcap_top
   import wcap_pkg::*;
#(
   parameter int NCH        = 4,
   parameter int SW         = 14,
   parameter int DEPTH      = 512,
   parameter int WIN        = 8,
   parameter int MAX_EV     = 8,
   parameter int WORD_W     = 32,
   parameter int DROP_W     = 16,
   parameter bit SIGNED_SMP = 1'b0,
   localparam int AW        = $clog2(DEPTH),
   localparam int EVW       = 1 + NCH * WIN,
   localparam int RCW       = $clog2(MAX_EV * EVW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH*SW-1:0] samp_in,
   input  logic              trig,
   input  logic              flush,
   input  logic [AW-1:0]     latency,
   input  logic              rd_en,
   output logic              rd_ready,
   output logic [RCW-1:0]    rd_count,
   output logic [WORD_W-1:0] rd_data,
   output logic              cap_busy,
   output logic              ovf,
   output logic              trig_drop,
   output logic [DROP_W-1:0] drop_cnt
);

   localparam int KW  = $clog2(WIN);
   localparam int CW  = $clog2(NCH);
   localparam int SLW = $clog2(MAX_EV);
   localparam int EW  = $clog2(MAX_EV + 1);
   localparam int HW  = WORD_W / 2;

   // elaboration-time parameter checks
   if (WIN < 2 || (1 << KW) != WIN) begin : g_bad_win
      $error("WIN must be a power of two, at least 2");
   end
   if (NCH < 2 || (1 << CW) != NCH) begin : g_bad_nch
      $error("NCH must be a power of two, at least 2");
   end
   if (MAX_EV < 2) begin : g_bad_ev
      $error("MAX_EV must be at least 2");
   end
   if (DEPTH <= 2 * WIN) begin : g_bad_depth
      $error("DEPTH must exceed twice WIN");
   end
   if (WORD_W <= SW || (WORD_W % 2) != 0) begin : g_bad_word
      $error("WORD_W must be even and wider than SW");
   end

   copy_state_e       cp_state;
   logic              act;
   logic [EW-1:0]     ev_cnt;
   logic [KW-1:0]     cp_idx;
   logic [AW-1:0]     cp_start;
   logic              cp_buf;
   logic [SLW-1:0]    cp_slot;
   logic              flush_pend;
   logic [HW-1:0]     trig_num;
   logic [HW-1:0]     tstamp;

   logic              full, swap, accept, drop, release_buf;
   logic              tgt_buf;
   logic [EW-1:0]     tgt_cnt;
   logic [AW:0]       start_ext, cp_sum;
   logic [AW-1:0]     cp_addr, wr_ptr;
   logic [NCH*SW-1:0] hist_q;
   logic              seq_hdr, seq_last;
   logic [SLW-1:0]    seq_slot;
   logic [CW-1:0]     seq_ch;
   logic [KW-1:0]     seq_idx;
   logic [WORD_W-1:0] bank_word [2];

   assign cap_busy    = (cp_state == CP_RUN);
   assign full        = (ev_cnt == EW'(MAX_EV));
   assign swap        = !cap_busy && !rd_ready && (full || (flush_pend && ev_cnt != '0));
   assign tgt_cnt     = swap ? '0 : ev_cnt;
   assign tgt_buf     = swap ? ~act : act;
   assign accept      = trig && !cap_busy && (tgt_cnt != EW'(MAX_EV));
   assign drop        = trig && !accept;
   assign release_buf = rd_ready && rd_en && seq_last;
   assign ovf         = full && rd_ready;

   // window start and running copy address, both modulo DEPTH
   always_comb begin
      if ({1'b0, wr_ptr} >= {1'b0, latency})
         start_ext = {1'b0, wr_ptr} - {1'b0, latency};
      else
         start_ext = {1'b0, wr_ptr} + (AW+1)'(DEPTH) - {1'b0, latency};
      cp_sum = {1'b0, cp_start} + (AW+1)'(cp_idx);
      if (cp_sum >= (AW+1)'(DEPTH))
         cp_addr = AW'(cp_sum - (AW+1)'(DEPTH));
      else
         cp_addr = AW'(cp_sum);
   end

   wcap_pipeline #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH)) pipe_i (
      .clk(clk), .rst_n(rst_n), .samp_in(samp_in),
      .rd_addr(cp_addr), .rd_data(hist_q), .wr_ptr(wr_ptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cp_state   <= CP_IDLE;
         act        <= 1'b0;
         ev_cnt     <= '0;
         cp_idx     <= '0;
         cp_start   <= '0;
         cp_buf     <= 1'b0;
         cp_slot    <= '0;
         flush_pend <= 1'b0;
         rd_ready   <= 1'b0;
         trig_num   <= '0;
         tstamp     <= '0;
         trig_drop  <= 1'b0;
         drop_cnt   <= '0;
      end else begin
         tstamp    <= tstamp + HW'(1);
         trig_num  <= trig_num + HW'(trig);
         trig_drop <= drop;
         drop_cnt  <= drop_cnt + DROP_W'(drop);
         ev_cnt    <= tgt_cnt + EW'(accept);
         act       <= tgt_buf;
         flush_pend <= swap ? 1'b0 : (flush_pend | (flush && ev_cnt != '0));
         if (swap)
            rd_ready <= 1'b1;
         else if (release_buf)
            rd_ready <= 1'b0;
         if (accept) begin
            cp_state <= CP_RUN;
            cp_idx   <= '0;
            cp_start <= start_ext[AW-1:0];
            cp_buf   <= tgt_buf;
            cp_slot  <= SLW'(tgt_cnt);
         end else if (cap_busy) begin
            cp_idx <= cp_idx + KW'(1);
            if (cp_idx == KW'(WIN - 1)) cp_state <= CP_IDLE;
         end
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_buf
      wcap_event_bank #(
         .NCH(NCH), .SW(SW), .WIN(WIN), .MAX_EV(MAX_EV),
         .WORD_W(WORD_W), .SIGNED_SMP(SIGNED_SMP)
      ) bank_i (
         .clk(clk),
         .hdr_we(accept && (tgt_buf == 1'(b))),
         .hdr_slot(SLW'(tgt_cnt)),
         .hdr_data({trig_num, tstamp}),
         .smp_we(cap_busy && (cp_buf == 1'(b))),
         .smp_slot(cp_slot),
         .smp_idx(cp_idx),
         .smp_data(hist_q),
         .rd_hdr(seq_hdr),
         .rd_slot(seq_slot),
         .rd_ch(seq_ch),
         .rd_idx(seq_idx),
         .rd_word(bank_word[b])
      );
   end

   wcap_read_seq #(.NCH(NCH), .WIN(WIN), .MAX_EV(MAX_EV)) rseq_i (
      .clk(clk), .rst_n(rst_n),
      .load(swap), .load_evs(ev_cnt),
      .adv(rd_ready && rd_en),
      .rd_hdr(seq_hdr), .rd_slot(seq_slot), .rd_ch(seq_ch), .rd_idx(seq_idx),
      .remain(rd_count), .last(seq_last)
   );

   assign rd_data = rd_ready ? bank_word[~act] : '0;

endmodule

// File: rtl/wcap_chk.sv
module wcap_chk #(
   parameter int NCH    = 4,
   parameter int DEPTH  = 512,
   parameter int WIN    = 8,
   parameter int MAX_EV = 8,
   parameter int DROP_W = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int EVW   = 1 + NCH * WIN,
   localparam int RCW   = $clog2(MAX_EV * EVW + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig,
   input logic [AW-1:0]     latency,
   input logic              rd_en,
   input logic              rd_ready,
   input logic [RCW-1:0]    rd_count,
   input logic              cap_busy,
   input logic              ovf,
   input logic              trig_drop,
   input logic [DROP_W-1:0] drop_cnt
);

   localparam int RUNW = $clog2(WIN + 1) + 1;
   logic [RUNW-1:0] busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n)        busy_run <= '0;
      else if (cap_busy) busy_run <= busy_run + RUNW'(1);
      else               busy_run <= '0;
   end

   // R1
   lat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> (latency <= AW'(DEPTH - WIN)));

   // R4
   busy_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_busy |-> (busy_run < RUNW'(WIN)));

   // R4
   busy_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cap_busy) |-> (busy_run == RUNW'(WIN)));

   // R4
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && cap_busy) |=> (trig_drop && drop_cnt == $past(drop_cnt) + DROP_W'(1)));

   // R7
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && ovf) |=> trig_drop);

   // R5
   handover_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_ready) |-> (rd_count != '0 && rd_count <= RCW'(MAX_EV * EVW)));

   // R8
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ready && rd_en && rd_count > RCW'(1)) |=> (rd_ready && rd_count == $past(rd_count) - RCW'(1)));

   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ready && !rd_en) |=> (rd_ready && $stable(rd_count)));

   // R8
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ready && rd_en && rd_count == RCW'(1)) |=> !rd_ready);

   // R4
   no_spurious_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trig |=> !trig_drop);

endmodule

bind wcap_top wcap_chk #(
   .NCH(NCH), .DEPTH(DEPTH), .WIN(WIN), .MAX_EV(MAX_EV), .DROP_W(DROP_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .trig(trig), .latency(latency), .rd_en(rd_en),
   .rd_ready(rd_ready), .rd_count(rd_count), .cap_busy(cap_busy), .ovf(ovf),
   .trig_drop(trig_drop), .drop_cnt(drop_cnt)
);

// File: tb/wcap_top_tb_top.sv
module wcap_top_tb_top;

   localparam int NCH    = 4;
   localparam int SW     = 14;
   localparam int DEPTH  = 512;
   localparam int WIN    = 8;
   localparam int MAX_EV = 8;
   localparam int WORD_W = 32;
   localparam int DROP_W = 16;
   localparam int AW     = $clog2(DEPTH);
   localparam int EVW    = 1 + NCH * WIN;
   localparam int RCW    = $clog2(MAX_EV * EVW + 1);

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NCH*SW-1:0] samp_in;
   logic              trig, flush, rd_en;
   logic [AW-1:0]     latency;
   logic              rd_ready, cap_busy, ovf, trig_drop;
   logic [RCW-1:0]    rd_count;
   logic [WORD_W-1:0] rd_data;
   logic [DROP_W-1:0] drop_cnt;

   int unsigned tb_cyc;
   int unsigned tnum;
   int unsigned exp_drops;
   int          n_chk;
   int          n_fail;
   int unsigned q_t[$];
   int unsigned q_n[$];
   int unsigned q_l[$];

   always #10ns clk = ~clk;

   wcap_top #(
      .NCH(NCH), .SW(SW), .DEPTH(DEPTH), .WIN(WIN), .MAX_EV(MAX_EV),
      .WORD_W(WORD_W), .DROP_W(DROP_W), .SIGNED_SMP(1'b0)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .samp_in(samp_in), .trig(trig), .flush(flush),
      .latency(latency), .rd_en(rd_en), .rd_ready(rd_ready), .rd_count(rd_count),
      .rd_data(rd_data), .cap_busy(cap_busy), .ovf(ovf), .trig_drop(trig_drop),
      .drop_cnt(drop_cnt)
   );

   function automatic logic [SW-1:0] smp_val(int unsigned n, int c);
      return SW'(n * 37 + c * 4099 + 5);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) tb_cyc <= 0;
      else        tb_cyc <= tb_cyc + 1;
   end

   always_comb begin
      for (int c = 0; c < NCH; c++) samp_in[c*SW +: SW] = smp_val(tb_cyc, c);
   end

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // called at a negedge; trigger in the current cycle
   task automatic fire(bit acc, string req);
      trig = 1'b1;
      if (acc) begin
         q_t.push_back(tb_cyc);
         q_n.push_back(tnum);
         q_l.push_back(int'(latency));
      end else begin
         exp_drops++;
      end
      tnum++;
      @(negedge clk);
      trig = 1'b0;
      check(trig_drop == !acc, req, "trig_drop after trigger", trig_drop, !acc);
   endtask

   task automatic pulse_flush();
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic wait_ready(string req);
      int t = 0;
      while (!rd_ready && t < 2000) begin
         @(negedge clk);
         t++;
      end
      check(rd_ready, req, "rd_ready after handover", rd_ready, 1);
   endtask

   // drain a handed-over buffer of nev events, comparing each word
   task automatic read_buf(int nev, string req);
      int unsigned cnt0;
      wait_ready(req);
      check(rd_count == RCW'(nev * EVW), req, "rd_count at handover", rd_count, nev * EVW);
      cnt0 = rd_count;
      idle(3);
      check(rd_count == RCW'(cnt0) && rd_ready, "R8", "count holds without rd_en", rd_count, cnt0);
      rd_en = 1'b1;
      for (int e = 0; e < nev; e++) begin
         int unsigned t0, n0, l0;
         bit ok = 1'b1;
         longint bad_a = 0, bad_e = 0;
         t0 = q_t.pop_front();
         n0 = q_n.pop_front();
         l0 = q_l.pop_front();
         for (int w = 0; w < EVW; w++) begin
            logic [WORD_W-1:0] ew;
            if (w == 0) begin
               ew = {16'(n0), 16'(t0)};
            end else begin
               int c = (w - 1) / WIN;
               int k = (w - 1) % WIN;
               ew = WORD_W'(smp_val(t0 - l0 + k, c));
            end
            if (rd_data !== ew && ok) begin
               ok = 1'b0;
               bad_a = rd_data;
               bad_e = ew;
            end
            @(negedge clk);
         end
         check(ok, req, "event content (R1 R2 R3)", bad_a, bad_e);
      end
      rd_en = 1'b0;
      check(!rd_ready, "R8", "rd_ready falls after last word", rd_ready, 0);
   endtask

   task automatic t_reset();
      check(rd_ready == 0, "R9", "rd_ready after reset", rd_ready, 0);
      check(rd_count == 0, "R9", "rd_count after reset", rd_count, 0);
      check(cap_busy == 0 && ovf == 0 && trig_drop == 0, "R9", "flags after reset",
            {cap_busy, ovf, trig_drop}, 0);
      check(drop_cnt == 0, "R9", "drop_cnt after reset", drop_cnt, 0);
   endtask

   task automatic t_basic();
      latency = AW'(20);
      idle(30);
      fire(1'b1, "R1");
      check(cap_busy, "R4", "busy after accepted trigger", cap_busy, 1);
      idle(12);
      check(!rd_ready, "R6", "no handover without flush", rd_ready, 0);
      pulse_flush();
      read_buf(1, "R6");
   endtask

   task automatic t_busy();
      latency = AW'(5);
      fire(1'b1, "R4");
      idle(WIN - 1);
      fire(1'b0, "R4");
      check(drop_cnt == DROP_W'(exp_drops), "R4", "drop_cnt after busy drop", drop_cnt, exp_drops);
      fire(1'b1, "R4");
      idle(12);
      pulse_flush();
      read_buf(2, "R4");
   endtask

   task automatic t_full();
      latency = AW'(40);
      for (int i = 0; i < MAX_EV; i++) begin
         fire(1'b1, "R5");
         idle(10);
      end
      wait_ready("R5");
      for (int i = 0; i < MAX_EV; i++) begin
         fire(1'b1, "R7");
         idle(10);
      end
      check(ovf, "R7", "ovf with both buffers full", ovf, 1);
      fire(1'b0, "R7");
      check(drop_cnt == DROP_W'(exp_drops), "R7", "drop_cnt after full drop", drop_cnt, exp_drops);
      read_buf(MAX_EV, "R5");
      read_buf(MAX_EV, "R8");
      check(!ovf, "R7", "ovf clears after drain", ovf, 0);
   endtask

   task automatic t_latency_edges();
      latency = AW'(0);
      fire(1'b1, "R1");
      idle(10);
      latency = AW'(DEPTH - WIN);
      fire(1'b1, "R1");
      idle(10);
      pulse_flush();
      read_buf(2, "R1");
   endtask

   task automatic t_empty_flush();
      pulse_flush();
      idle(5);
      check(!rd_ready, "R6", "flush on empty buffer ignored", rd_ready, 0);
      latency = AW'(3);
      fire(1'b1, "R6");
      idle(12);
      check(!rd_ready, "R6", "no pending flush kept", rd_ready, 0);
      pulse_flush();
      read_buf(1, "R6");
   endtask

   initial begin
      n_chk = 0; n_fail = 0; tnum = 0; exp_drops = 0;
      rst_n = 1'b0; trig = 1'b0; flush = 1'b0; rd_en = 1'b0; latency = '0;
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic();
      t_busy();
      t_full();
      t_latency_edges();
      t_empty_flush();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20ns * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule